// File: doc/BRIEF.md
# Sequential Bit-Population Counter

This block finds how many bits are set in a data word. It does this over several clock cycles rather than with a wide adder tree. A pulse on `start` while the block is idle captures the word into a working shift register and presets the tally register to all ones. A four-state controller then runs the loop. First it bumps the tally. Next it tests whether the working register has emptied. If not, it shifts the most significant bit out into a one-bit holding flop, tests that bit, and returns to the bump step only when the bit was a 1. The first bump wraps the all-ones preset to zero, so one increment path serves both the clear and the counting.

The loop ends as soon as the last set bit has left the register. The run time therefore depends on the number of ones in the word and on the position of its lowest set bit. When `idle` returns high, `count_out` holds the result. It keeps that value until the next accepted start.

The controller state sits on two flip-flops, encoded as follows:

| Step | Encoding |
|---|---|
| wait | 00 |
| tally | 01 |
| shift | 10 |
| test | 11 |

Top module: `bitcount_seq`

## Requirements
- R1: After a synchronous reset, `idle` is 1 and `count_out` is 0.
- R2: A start accepted while idle yields, once `idle` is again 1, a `count_out` equal to the number of 1 bits in the word captured with that start.
- R3: An all-zero word gives a count of 0, and `idle` is low for exactly one cycle.
- R4: An all-ones word gives a count equal to the word width W.
- R5: Bits leave most-significant first. For a nonzero word with lowest set bit at index j, `idle` stays low for (ones + 1) + 2·(W − j) cycles.
- R6: `start` and `data_in` are ignored while busy. A run disturbed by them gives the same count and the same latency as an undisturbed one.
- R7: In the cycle after a start is accepted, `idle` is 0 and `count_out` shows the all-ones preset.
- R8: While idle with `start` low, `count_out` and `idle` hold their values.
- R9: While busy, `count_out` changes only by +1 (modulo 2^CW) from one cycle to the next. When idle, it never exceeds W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a count when sampled high while idle |
| data_in | input | W | Word whose set bits are counted |
| count_out | output | CW = clog2(W+1) | Tally register; the result once idle |
| idle | output | 1 | High while waiting for a start |

## Verification
Two functions can fall in the same cycle: the final tally step that returns the block to idle, and a start request. The bench holds `start` high across the end of a run with a second word already on `data_in`. It then checks three things in order. First, one idle cycle appears and shows the first result. Second, the preset is visible on the following cycle. Third, the second word's count and latency follow. Start pulses injected mid-run are judged by comparing count and busy-cycle length against values the bench computes from the word alone.

// File: rtl/bco_pkg.sv
package bco_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'b00,
    ST_TALLY = 2'b01,
    ST_SHIFT = 2'b10,
    ST_TEST  = 2'b11
  } bco_state_t;
endpackage

// File: rtl/bco_ctrl.sv
module bco_ctrl
  import bco_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic zero,
  input  logic e_bit,
  output logic load,
  output logic inc,
  output logic shift,
  output logic idle
);
  bco_state_t st, st_nxt;

  always_comb begin
    st_nxt = st;
    case (st)
      ST_WAIT:  if (start) st_nxt = ST_TALLY;
      ST_TALLY: st_nxt = zero ? ST_WAIT : ST_SHIFT;
      ST_SHIFT: st_nxt = ST_TEST;
      ST_TEST:  st_nxt = e_bit ? ST_TALLY : ST_SHIFT;
      default:  st_nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_WAIT;
      idle <= 1'b1;
    end else begin
      st   <= st_nxt;
      idle <= (st_nxt == ST_WAIT);
    end
  end

  assign load  = (st == ST_WAIT) && start;
  assign inc   = (st == ST_TALLY);
  assign shift = (st == ST_SHIFT);
endmodule

// File: rtl/bco_datapath.sv
module bco_datapath #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          inc,
  input  logic          shift,
  input  logic [W-1:0]  din,
  output logic          zero,
  output logic          e_bit,
  output logic [CW-1:0] tally
);
  logic [W-1:0] work;

  always_ff @(posedge clk) begin
    if (rst) begin
      work  <= '0;
      e_bit <= 1'b0;
      tally <= '0;
    end else begin
      if (load) begin
        work  <= din;
        tally <= '1;
      end else begin
        if (shift) begin
          work  <= {work[W-2:0], 1'b0};
          e_bit <= work[W-1];
        end
        if (inc) tally <= tally + 1'b1;
      end
    end
  end

  assign zero = (work == '0);
endmodule

// File: rtl/bitcount_seq.sv
module bitcount_seq #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  data_in,
  output logic [CW-1:0] count_out,
  output logic          idle
);
  logic load, inc, shift, zero, e_bit;

  bco_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .zero(zero), .e_bit(e_bit),
    .load(load), .inc(inc), .shift(shift), .idle(idle)
  );

  bco_datapath #(.W(W), .CW(CW)) u_dp (
    .clk(clk), .rst(rst), .load(load), .inc(inc), .shift(shift),
    .din(data_in), .zero(zero), .e_bit(e_bit), .tally(count_out)
  );
endmodule

// File: rtl/bitcount_seq_chk.sv
module bitcount_seq_chk #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [CW-1:0] count_out,
  input logic          idle
);
  AST_PRESET_SHOWN: assert property (@(posedge clk) disable iff (rst)
    idle && start |=> !idle && count_out == {CW{1'b1}}); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    idle && !start |=> idle && $stable(count_out)); // R8

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    !idle |=> (count_out == $past(count_out)) ||
              (count_out == CW'($past(count_out) + 1'b1))); // R9

  AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (rst)
    idle |-> count_out <= CW'(W)); // R9
endmodule

bind bitcount_seq bitcount_seq_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .count_out(count_out), .idle(idle)
);

// File: tb/bitcount_seq_test.sv
`timescale 1ns/1ps
module bitcount_seq_test;
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  data_in = '0;
  logic [CW-1:0] count_out;
  logic          idle;
  int tests = 0;
  int fails = 0;

  bitcount_seq #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .data_in(data_in),
    .count_out(count_out), .idle(idle)
  );

  always #10 clk = ~clk;

  function automatic int pop(input logic [W-1:0] d);
    int n = 0;
    for (int i = 0; i < W; i++) n += d[i];
    return n;
  endfunction

  function automatic int lat(input logic [W-1:0] d);
    int j = 0;
    if (d == '0) return 1;
    for (int i = W - 1; i >= 0; i--) if (d[i]) j = i;
    return pop(d) + 1 + 2 * (W - j);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts a run; optionally pokes start with a decoy word mid-run (R6).
  task automatic run_word(input string req, input logic [W-1:0] d, input bit disturb);
    int busy = 0;
    @(negedge clk);
    start = 1'b1; data_in = d;
    @(negedge clk);
    start = 1'b0; data_in = ~d;
    check("R7 busy", idle, 0);
    check("R7 preset", count_out, (1 << CW) - 1);
    while (!idle && busy < 1000) begin
      busy++;
      if (disturb && busy == 3) start = 1'b1;
      if (disturb && busy == 5) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check({req, " count"}, count_out, pop(d));
    check("R5 latency", busy, lat(d));
  endtask

  task automatic t_reset;
    check("R1 idle", idle, 1);
    check("R1 count", count_out, 0);
  endtask

  task automatic t_hold;
    repeat (5) @(negedge clk);
    data_in = 8'h5A;
    check("R8 idle", idle, 1);
    check("R8 count", count_out, W);
    repeat (3) @(negedge clk);
    check("R8 count held", count_out, W);
  endtask

  // Start held high across the end of a run with the next word waiting.
  task automatic t_back_to_back;
    logic [W-1:0] a = 8'b0011_0100;
    logic [W-1:0] b = 8'b1110_0001;
    int busy = 0;
    @(negedge clk);
    start = 1'b1; data_in = a;
    @(negedge clk);
    data_in = b;
    while (!idle && busy < 1000) begin busy++; @(negedge clk); end
    check("R6 first latency", busy, lat(a));
    check("R2 first count", count_out, pop(a));
    @(negedge clk);
    start = 1'b0;
    check("R7 second preset", count_out, (1 << CW) - 1);
    busy = 0;
    while (!idle && busy < 1000) begin busy++; @(negedge clk); end
    check("R2 second count", count_out, pop(b));
    check("R5 second latency", busy, lat(b));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_word("R3", 8'h00, 1'b0);
    run_word("R4", 8'hFF, 1'b0);
    t_hold();
    run_word("R2", 8'h80, 1'b0);
    run_word("R2", 8'h01, 1'b0);
    run_word("R2", 8'hA5, 1'b0);
    run_word("R2", 8'h3C, 1'b0);
    run_word("R6", 8'h96, 1'b1);
    t_back_to_back();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule